// File: doc/BRIEF.md
# Background Debug Command Executor

This block sits behind an already-deserialized debug host link and turns a stream of command bytes into single memory-bus accesses. Each command starts with one opcode byte. Read and write commands then carry a 16-bit address (high byte first), and write commands also carry a 16-bit data field (high byte first). The block performs one byte or word access on the memory bus, with the debug register window either mapped in or mapped out. For reads, it returns the 16-bit result to the host side with a one-cycle done pulse.

The block holds a small debug status byte that it serves itself at address 0xFF01 when the window is mapped in. Bit 7 is the debug enable and bit 6 reports that background mode is active. A background-entry command takes effect only when the enable bit is already set. While the block owns the bus, it waits for a bus-free grant and gives up after a bounded wait. If an access outlasts the grant cycle, the block freezes the CPU clock. It also flags commands that arrive too close together, opcodes it does not know, and word addresses that are not aligned.

Top module: `bgdbg_exec`

## Requirements
- R1: Recognised opcodes are 0x90 (background entry), 0xE4/0xEC (byte/word read, window in), 0xE0/0xE8 (byte/word read, window out), 0xC4/0xCC (byte/word write, window in) and 0xC0/0xC8 (byte/word write, window out). Any other opcode byte is dropped, makes no bus access, returns no data, and pulses `err_opcode` for one cycle. The decoder then waits for a new opcode.
- R2: A read or write opcode is followed by the address high byte and then the address low byte. A write then takes the data high byte and then the data low byte. Background entry takes no operand bytes.
- R3: A byte access at an even address uses the high lane (`bus_be`=2'b10, bit 1 = bits 15:8). A byte access at an odd address uses the low lane (`bus_be`=2'b01). A byte read returns the addressed lane in place and zero in the other lane.
- R4: A word access uses `bus_be`=2'b11 at an even address. An odd word address has bit 0 cleared before use, and `err_align` pulses for one cycle.
- R5: Window-in opcodes (0xE4, 0xEC, 0xC4, 0xCC) drive `bus_win`=1. Window-out opcodes drive `bus_win`=0.
- R6: A window-in access whose even-aligned address is 0xFF00 is served internally, with no bus access. Its low byte is the status byte {enable, background, 6'b0}, so it reads 0x00 after reset, 0x80 once enabled, and 0xC0 in background mode. Its high byte reads 0.
- R7: A window-in write whose low lane is enabled at 0xFF01 sets the enable bit when data bit 7 is 1 and leaves it unchanged when bit 7 is 0. Only reset clears the enable bit, which appears on `dbg_en`.
- R8: Background entry sets `bg_active` only when `dbg_en` is 1. When `dbg_en` is 0 it has no effect.
- R9: A bus access holds `bus_req` with stable address, lanes and data until `bus_ack`. A read then gives a one-cycle `tx_valid` pulse with the result on `tx_data`. Writes produce no `tx_valid`.
- R10: If `bus_grant` arrives without `bus_ack`, `cpu_freeze` is high from the next cycle through the cycle in which `bus_ack` is seen. In that case it is high for as many cycles as the ack came after the grant. A grant and ack in the same cycle never raise `cpu_freeze`.
- R11: If `bus_grant` has not arrived by the 128th cycle of the request, the access is abandoned, `err_timeout` pulses, and no data is returned. A grant in the 128th cycle still completes the access normally.
- R12: A known opcode arriving fewer than 150 cycles after the previous known opcode pulses `err_proto`, and the command still executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Host byte strobe |
| rx_byte | input | 8 | Host byte |
| tx_valid | output | 1 | Read data valid pulse |
| tx_data | output | 16 | Read result |
| bus_req | output | 1 | Block holds or requests the bus |
| bus_grant | input | 1 | Bus-free grant |
| bus_ack | input | 1 | Access complete |
| bus_addr | output | 16 | Access address |
| bus_we | output | 1 | Write access |
| bus_be | output | 2 | Lane enables, bit 1 = high byte |
| bus_win | output | 1 | Debug window mapped in |
| bus_wdata | output | 16 | Write data, disabled lane zero |
| bus_rdata | input | 16 | Read data from memory |
| cpu_freeze | output | 1 | CPU clock freeze |
| dbg_en | output | 1 | Status enable bit |
| bg_active | output | 1 | Background mode active |
| err_opcode | output | 1 | Unknown opcode pulse |
| err_align | output | 1 | Misaligned word address pulse |
| err_timeout | output | 1 | Grant wait expired pulse |
| err_proto | output | 1 | Command spacing violation pulse |

## Verification
The hardest situations to reach from the ports are the edge of the grant wait and a multi-cycle hold. They depend on exactly when the memory side answers, not on the command bytes. The bench drives the bus through a responder model whose grant delay and ack delay are set per command. This lets it place the grant in the 128th waiting cycle and then one cycle later, and stretch the ack a known number of cycles past the grant, so that the count of frozen cycles can be compared exactly. The spacing check is reached by sending a second command about twenty cycles after the first, while every other command is spaced well beyond the limit.

// File: rtl/bgdbg_pkg.sv
package bgdbg_pkg;

  typedef enum logic [7:0] {
    OP_BGND    = 8'h90,
    OP_RD_BD_B = 8'hE4,
    OP_RD_BD_W = 8'hEC,
    OP_RD_B    = 8'hE0,
    OP_RD_W    = 8'hE8,
    OP_WR_BD_B = 8'hC4,
    OP_WR_BD_W = 8'hCC,
    OP_WR_B    = 8'hC0,
    OP_WR_W    = 8'hC8
  } opcode_e;

  typedef struct packed {
    logic known;
    logic bgnd;
    logic write;
    logic word;
    logic win;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_OP, ST_AH, ST_AL, ST_DH, ST_DL, ST_EXEC, ST_REQ, ST_HOLD
  } state_e;

endpackage

// File: rtl/bgdbg_decode.sv
module bgdbg_decode
  import bgdbg_pkg::*;
(
  input  logic [7:0] op,
  output cmd_t       cmd
);
  always_comb begin
    cmd = '0;
    cmd.known = 1'b1;
    case (op)
      OP_BGND:    cmd.bgnd = 1'b1;
      OP_RD_BD_B: cmd.win  = 1'b1;
      OP_RD_BD_W: begin cmd.win = 1'b1; cmd.word = 1'b1; end
      OP_RD_B:    ;
      OP_RD_W:    cmd.word = 1'b1;
      OP_WR_BD_B: begin cmd.win = 1'b1; cmd.write = 1'b1; end
      OP_WR_BD_W: begin cmd.win = 1'b1; cmd.write = 1'b1; cmd.word = 1'b1; end
      OP_WR_B:    cmd.write = 1'b1;
      OP_WR_W:    begin cmd.write = 1'b1; cmd.word = 1'b1; end
      default:    cmd.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/bgdbg_gap_mon.sv
module bgdbg_gap_mon #(
  parameter int MIN_GAP = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic violate
);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);

  logic [GAP_W-1:0] since_q;

  // since_q holds the number of edges since the last accepted opcode
  assign violate = accept && (since_q < GAP_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= GAP_MAX;
    end else if (accept) begin
      since_q <= GAP_W'(1);
    end else if (since_q < GAP_MAX) begin
      since_q <= since_q + GAP_W'(1);
    end
  end
endmodule

// File: rtl/bgdbg_status.sv
module bgdbg_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       bg_req,
  output logic       en,
  output logic       bg,
  output logic [7:0] stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
      bg <= 1'b0;
    end else begin
      if (wr_stb && wr_byte[7]) en <= 1'b1;
      if (bg_req && en)         bg <= 1'b1;
    end
  end

  assign stat = {en, bg, 6'b0};
endmodule

// File: rtl/bgdbg_lanes.sv
module bgdbg_lanes #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   rd_in,
  input  logic [DATA_W-1:0]   wd_in,
  output logic [DATA_W-1:0]   rd_out,
  output logic [DATA_W-1:0]   wd_out
);
  localparam int LANES = DATA_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rd_out[i*8 +: 8] = be[i] ? rd_in[i*8 +: 8] : 8'h00;
    assign wd_out[i*8 +: 8] = be[i] ? wd_in[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/bgdbg_exec.sv
module bgdbg_exec
  import bgdbg_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter int          DATA_W        = 16,
  parameter int          GRANT_TIMEOUT = 128,
  parameter int          MIN_GAP       = 150,
  parameter logic [15:0] STAT_ADDR     = 16'hFF01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W/8-1:0] bus_be,
  output logic              bus_win,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_freeze,
  output logic              dbg_en,
  output logic              bg_active,
  output logic              err_opcode,
  output logic              err_align,
  output logic              err_timeout,
  output logic              err_proto
);
  localparam int LANES = DATA_W / 8;
  localparam int TMR_W = $clog2(GRANT_TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(GRANT_TIMEOUT - 1);

  state_e               state;
  cmd_t                 dec, cmd_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [LANES-1:0]     be_q, be_n;
  logic [TMR_W-1:0]     tmr;
  logic                 freeze_q;
  logic                 op_seen, accept, gap_bad;
  logic                 hit_stat, stat_wr;
  logic [7:0]           stat;
  logic [DATA_W-1:0]    rd_steer, wd_mask, stat_rd;

  bgdbg_decode u_dec (.op(rx_byte), .cmd(dec));

  assign op_seen = (state == ST_OP) && rx_valid;
  assign accept  = op_seen && dec.known;

  bgdbg_gap_mon #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk(clk), .rst(rst), .accept(accept), .violate(gap_bad)
  );

  // lane choice: word -> all lanes, byte -> even address on high lane
  always_comb begin
    if (cmd_q.word) be_n = '1;
    else            be_n = addr_q[0] ? LANES'(1) : LANES'(1) << (LANES - 1);
  end

  assign hit_stat = cmd_q.win && (addr_q[ADDR_W-1:1] == STAT_ADDR[ADDR_W-1:1]);
  assign stat_wr  = (state == ST_EXEC) && hit_stat && cmd_q.write && be_n[0];

  bgdbg_status u_stat (
    .clk(clk), .rst(rst), .wr_stb(stat_wr), .wr_byte(wdata_q[7:0]),
    .bg_req(accept && dec.bgnd), .en(dbg_en), .bg(bg_active), .stat(stat)
  );

  assign stat_rd = {{(DATA_W-8){1'b0}}, (be_n[0] ? stat : 8'h00)};

  bgdbg_lanes #(.DATA_W(DATA_W)) u_lanes (
    .be(be_q), .rd_in(bus_rdata), .wd_in(wdata_q),
    .rd_out(rd_steer), .wd_out(wd_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OP;
      cmd_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      tmr         <= '0;
      freeze_q    <= 1'b0;
      tx_valid    <= 1'b0;
      tx_data     <= '0;
      err_opcode  <= 1'b0;
      err_align   <= 1'b0;
      err_timeout <= 1'b0;
      err_proto   <= 1'b0;
    end else begin
      tx_valid    <= 1'b0;
      err_opcode  <= 1'b0;
      err_align   <= 1'b0;
      err_timeout <= 1'b0;
      err_proto   <= gap_bad;
      case (state)
        ST_OP: begin
          if (op_seen) begin
            if (!dec.known) begin
              err_opcode <= 1'b1;
            end else if (!dec.bgnd) begin
              cmd_q <= dec;
              state <= ST_AH;
            end
          end
        end
        ST_AH: begin
          if (rx_valid) begin
            addr_q[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
            state              <= ST_AL;
          end
        end
        ST_AL: begin
          if (rx_valid) begin
            addr_q[7:0] <= cmd_q.word ? {rx_byte[7:1], 1'b0} : rx_byte;
            err_align   <= cmd_q.word && rx_byte[0];
            state       <= cmd_q.write ? ST_DH : ST_EXEC;
          end
        end
        ST_DH: begin
          if (rx_valid) begin
            wdata_q[DATA_W-1:8] <= rx_byte[DATA_W-9:0];
            state               <= ST_DL;
          end
        end
        ST_DL: begin
          if (rx_valid) begin
            wdata_q[7:0] <= rx_byte;
            state        <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          be_q <= be_n;
          if (hit_stat) begin
            if (!cmd_q.write) begin
              tx_valid <= 1'b1;
              tx_data  <= stat_rd;
            end
            state <= ST_OP;
          end else begin
            tmr   <= '0;
            state <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_grant) begin
            if (bus_ack) begin
              if (!cmd_q.write) begin
                tx_valid <= 1'b1;
                tx_data  <= rd_steer;
              end
              state <= ST_OP;
            end else begin
              freeze_q <= 1'b1;
              state    <= ST_HOLD;
            end
          end else if (tmr == TMR_LAST) begin
            err_timeout <= 1'b1;
            state       <= ST_OP;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_HOLD: begin
          if (bus_ack) begin
            freeze_q <= 1'b0;
            if (!cmd_q.write) begin
              tx_valid <= 1'b1;
              tx_data  <= rd_steer;
            end
            state <= ST_OP;
          end
        end
        default: state <= ST_OP;
      endcase
    end
  end

  assign bus_req    = (state == ST_REQ) || (state == ST_HOLD);
  assign bus_addr   = addr_q;
  assign bus_we     = cmd_q.write;
  assign bus_be     = be_q;
  assign bus_win    = cmd_q.win;
  assign bus_wdata  = wd_mask;
  assign cpu_freeze = freeze_q;
endmodule

// File: rtl/bgdbg_exec_chk.sv
module bgdbg_exec_chk (
  input logic        clk,
  input logic        rst,
  input logic        tx_valid,
  input logic        bus_req,
  input logic [15:0] bus_addr,
  input logic [1:0]  bus_be,
  input logic [15:0] bus_wdata,
  input logic        cpu_freeze,
  input logic        dbg_en,
  input logic        bg_active
);
  a_r3_lane_selected: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> ($countones(bus_be) == 1 || bus_be == 2'b11));

  a_r4_word_even: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_be == 2'b11) |-> !bus_addr[0]);

  a_r7_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    dbg_en |=> dbg_en);

  a_r8_bg_needs_en: assert property (@(posedge clk) disable iff (rst)
    bg_active |-> dbg_en);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);

  a_r9_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)));

  a_r10_freeze_in_hold: assert property (@(posedge clk) disable iff (rst)
    cpu_freeze |-> bus_req);
endmodule

bind bgdbg_exec bgdbg_exec_chk u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .bus_req(bus_req),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .cpu_freeze(cpu_freeze), .dbg_en(dbg_en), .bg_active(bg_active)
);

// File: tb/bgdbg_exec_tb.sv
module bgdbg_exec_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        tx_valid;
  logic [15:0] tx_data;
  logic        bus_req;
  logic        bus_grant = 1'b0;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_addr;
  logic        bus_we;
  logic [1:0]  bus_be;
  logic        bus_win;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = 16'h0000;
  logic        cpu_freeze, dbg_en, bg_active;
  logic        err_opcode, err_align, err_timeout, err_proto;

  always #10 clk = ~clk;

  bgdbg_exec u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_data(tx_data), .bus_req(bus_req),
    .bus_grant(bus_grant), .bus_ack(bus_ack), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_be(bus_be), .bus_win(bus_win),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_freeze(cpu_freeze),
    .dbg_en(dbg_en), .bg_active(bg_active), .err_opcode(err_opcode),
    .err_align(err_align), .err_timeout(err_timeout), .err_proto(err_proto)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] mem [256];
  int gnt_dly = 0;
  int ack_dly = 0;
  int rcnt = 0;
  int m_tx, m_bus, m_frz;
  logic [15:0] m_txd, m_addr;
  logic [1:0]  m_be;
  logic        m_win, m_eop, m_eal, m_eto, m_epr;

  // row: op, addr, wdata, expected tx, expected be, expected win, read flag
  localparam int NV = 12;
  localparam logic [59:0] VEC [NV] = '{
    {8'hE8, 16'h0010, 16'h0000, 16'h5208, 2'b11, 1'b0, 1'b1},
    {8'hE0, 16'h0010, 16'h0000, 16'h5200, 2'b10, 1'b0, 1'b1},
    {8'hE0, 16'h0011, 16'h0000, 16'h0008, 2'b01, 1'b0, 1'b1},
    {8'hEC, 16'h0020, 16'h0000, 16'h4A10, 2'b11, 1'b1, 1'b1},
    {8'hE4, 16'h0021, 16'h0000, 16'h0010, 2'b01, 1'b1, 1'b1},
    {8'hC8, 16'h0030, 16'h1234, 16'h0000, 2'b11, 1'b0, 1'b0},
    {8'hE8, 16'h0030, 16'h0000, 16'h1234, 2'b11, 1'b0, 1'b1},
    {8'hC0, 16'h0041, 16'h00AB, 16'h0000, 2'b01, 1'b0, 1'b0},
    {8'hE8, 16'h0040, 16'h0000, 16'h7AAB, 2'b11, 1'b0, 1'b1},
    {8'hC4, 16'h0050, 16'hCD00, 16'h0000, 2'b10, 1'b1, 1'b0},
    {8'hEC, 16'h0050, 16'h0000, 16'hCD28, 2'b11, 1'b1, 1'b1},
    {8'hCC, 16'h0060, 16'hBEEF, 16'h0000, 2'b11, 1'b1, 1'b0}
  };

  // bus responder and output monitor, both at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (!bus_req) begin
        rcnt = 0; bus_grant = 1'b0; bus_ack = 1'b0;
      end else begin
        rcnt++;
        bus_grant = (rcnt > gnt_dly);
        bus_ack   = (rcnt > gnt_dly + ack_dly);
        bus_rdata = mem[bus_addr[8:1]];
        if (bus_ack && bus_we) begin
          if (bus_be[1]) mem[bus_addr[8:1]][15:8] = bus_wdata[15:8];
          if (bus_be[0]) mem[bus_addr[8:1]][7:0]  = bus_wdata[7:0];
        end
        m_addr = bus_addr; m_be = bus_be; m_win = bus_win;
        if (bus_ack) m_bus++;
      end
      if (tx_valid)    begin m_tx++; m_txd = tx_data; end
      if (cpu_freeze)  m_frz++;
      if (err_opcode)  m_eop = 1'b1;
      if (err_align)   m_eal = 1'b1;
      if (err_timeout) m_eto = 1'b1;
      if (err_proto)   m_epr = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    m_tx = 0; m_bus = 0; m_frz = 0; m_txd = 16'h0; m_addr = 16'h0;
    m_be = 2'b00; m_win = 1'b0;
    m_eop = 1'b0; m_eal = 1'b0; m_eto = 1'b0; m_epr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [15:0] a, input logic [15:0] d);
    send_byte(op);
    if (op == 8'hE4 || op == 8'hEC || op == 8'hE0 || op == 8'hE8 ||
        op == 8'hC4 || op == 8'hCC || op == 8'hC0 || op == 8'hC8) begin
      send_byte(a[15:8]); send_byte(a[7:0]);
      if (op[5] == 1'b0) begin send_byte(d[15:8]); send_byte(d[7:0]); end
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [15:0] a, input logic [15:0] d,
                         input int gd, input int ad);
    gnt_dly = gd; ack_dly = ad;
    clr_mon();
    send_cmd(op, a, d);
    repeat (300) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'h5A, 8'(i)};
    clr_mon();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R9 reset bus_req", bus_req, 0);
    chk("R9 reset tx_valid", tx_valid, 0);
    chk("R10 reset freeze", cpu_freeze, 0);
    chk("R7 reset dbg_en", dbg_en, 0);
    chk("R8 reset bg_active", bg_active, 0);

    // R6 status read after reset, served internally
    run_cmd(8'hE4, 16'hFF01, 16'h0, 0, 0);
    chk("R6 status reset value", m_txd, 16'h0000);
    chk("R6 status no bus access", m_bus, 0);
    chk("R6 status returned", m_tx, 1);

    // R8 background ignored while disabled
    run_cmd(8'h90, 16'h0, 16'h0, 0, 0);
    chk("R8 bg ignored when disabled", bg_active, 0);

    // R7 write with bit 7 clear keeps enable clear, bit 7 set enables
    run_cmd(8'hC4, 16'hFF01, 16'h0000, 0, 0);
    chk("R7 bit7 clear no enable", dbg_en, 0);
    run_cmd(8'hC4, 16'hFF01, 16'h0080, 0, 0);
    chk("R7 enable set", dbg_en, 1);
    chk("R6 status write no bus", m_bus, 0);
    run_cmd(8'hE4, 16'hFF01, 16'h0, 0, 0);
    chk("R6 status enabled", m_txd, 16'h0080);

    // R8 background with enable set, R2 next byte is an opcode again
    run_cmd(8'h90, 16'h0, 16'h0, 0, 0);
    chk("R8 bg entered", bg_active, 1);
    run_cmd(8'hE4, 16'hFF01, 16'h0, 0, 0);
    chk("R6 status in background", m_txd, 16'h00C0);
    chk("R2 command after bg decoded", m_tx, 1);

    // vector table: R2 framing, R3 lanes, R5 window, R9 done, R10 no freeze
    for (int v = 0; v < NV; v++) begin
      run_cmd(VEC[v][59:52], VEC[v][51:36], VEC[v][35:20], 2, 0);
      chk($sformatf("R3 row %0d lanes", v), m_be, VEC[v][3:2]);
      chk($sformatf("R5 row %0d window", v), m_win, VEC[v][1]);
      chk($sformatf("R9 row %0d done count", v), m_tx, VEC[v][0] ? 1 : 0);
      if (VEC[v][0]) chk($sformatf("R2 row %0d data", v), m_txd, VEC[v][19:4]);
      chk($sformatf("R10 row %0d single-cycle no freeze", v), m_frz, 0);
      chk($sformatf("R12 row %0d no spacing error", v), m_epr, 0);
    end

    // R1 unknown opcode
    run_cmd(8'h55, 16'h0, 16'h0, 0, 0);
    chk("R1 unknown flagged", m_eop, 1);
    chk("R1 unknown no bus", m_bus, 0);
    chk("R1 unknown no data", m_tx, 0);
    run_cmd(8'hE8, 16'h0002, 16'h0, 0, 0);
    chk("R1 decoder back to idle", m_txd, 16'h5B01);

    // R4 misaligned word
    run_cmd(8'hE8, 16'h0013, 16'h0, 0, 0);
    chk("R4 align flag", m_eal, 1);
    chk("R4 forced even address", m_addr, 16'h0012);
    chk("R4 aligned data", m_txd, 16'h5309);

    // R10 multi-cycle hold freezes
    run_cmd(8'hE8, 16'h0002, 16'h0, 3, 4);
    chk("R10 freeze cycles", m_frz, 4);
    chk("R10 data after hold", m_txd, 16'h5B01);

    // R11 grant at the 128th cycle succeeds, one later times out
    run_cmd(8'hE8, 16'h0004, 16'h0, 127, 0);
    chk("R11 last-cycle grant no timeout", m_eto, 0);
    chk("R11 last-cycle grant data", m_txd, 16'h5802);
    run_cmd(8'hE8, 16'h0004, 16'h0, 128, 0);
    chk("R11 timeout flagged", m_eto, 1);
    chk("R11 timeout no data", m_tx, 0);

    // R12 commands too close together
    gnt_dly = 0; ack_dly = 0;
    clr_mon();
    send_cmd(8'hE8, 16'h0006, 16'h0);
    repeat (20) @(negedge clk);
    chk("R12 first command clean", m_epr, 0);
    clr_mon();
    send_cmd(8'hE8, 16'h0008, 16'h0);
    repeat (300) @(negedge clk);
    chk("R12 spacing flagged", m_epr, 1);
    chk("R12 command still runs", m_txd, 16'h5E04);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule